// File: doc/BRIEF.md
# Command Sequencer Execution Engine

This block steps through a short program of 32-bit command words held in an external command memory. It fetches one word at a time, decodes it and acts on it. The engine can do three things. It can issue a register write through a dedicated write port. It can stall for an exact number of clocks on its own down-counter. It can launch an external timeout counter and carry on without pausing.

The host sets an inclusive window of command addresses and raises `enable`. The engine runs from the first address upward. When the command at the last address completes, it raises `done`, and `done` stays high until the host lowers `enable`. Lowering `enable` at any point abandons the program, including a wait that is in progress. The memory is read synchronously with one cycle of latency, so a block RAM fits directly behind the read port.

Top module: `cmdseq_engine`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `done`, `reg_wr_en` and `tmo_start` are low and `mem_addr` is zero.
- R2: When `enable` rises while the engine is idle, the engine starts from `start_addr`. The first command's effect is visible after the third rising edge, counted from the first edge that samples `enable` high.
- R3: A word with bit 31 set is a write. It produces a one-cycle `reg_wr_en` pulse, with `reg_wr_addr` taken from bits 30..24 and `reg_wr_data` from bits 23..0. Bit 30 is part of the address here and does not change the operation. Commands that do not stall issue every two cycles.
- R4: A word with bits 31..30 = 00 is a wait of N = bits 29..0 clocks. It adds exactly N cycles before the next fetch (N = 0 adds none) and drives no output pulse while it counts.
- R5: A word with bits 31..30 = 01 is a timeout launch. It produces a one-cycle `tmo_start` pulse, with `tmo_count` taken from bits 29..0, and does not stall the command stream.
- R6: After the command at `end_addr` completes (for a trailing wait, this is when its count runs out), `done` rises. `done` stays high while `enable` stays high, and no further commands run.
- R7: Lowering `enable` clears `done` on the next edge. A later rise of `enable` runs the program again from `start_addr`.
- R8: Lowering `enable` in any state abandons the program on the next edge. A pending wait is dropped, and no further write or timeout pulse follows.
- R9: Command addresses advance by one from `start_addr` up to `end_addr` inclusive. A window that ends at the last memory address, and a window of a single command, both run correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run request from the host; low aborts |
| start_addr | input | ADDR_W | First command address |
| end_addr | input | ADDR_W | Last command address (inclusive) |
| mem_addr | output | ADDR_W | Command memory read address |
| mem_rdata | input | 32 | Command word, one cycle after the address |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_addr | output | 7 | Register write address |
| reg_wr_data | output | 24 | Register write data |
| tmo_start | output | 1 | Timeout counter launch strobe |
| tmo_count | output | 30 | Timeout period in clocks |
| done | output | 1 | Program finished |

## Verification
The bench builds the engine with `ADDR_W` = 5, so the command memory has 32 words. This makes it cheap to run a window that ends exactly at the top address, where the address counter must stop and not wrap. A stall of 1000 clocks can still finish well inside the run limit, which lets the same program be aborted partway through its wait and then rerun to completion. The 30-bit count fields are checked with all-ones values, and a write to an address with its top bit set checks that bit 30 is not read as part of the opcode.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
  localparam int CMD_W  = 32;
  localparam int REG_AW = 7;
  localparam int REG_DW = 24;
  localparam int TIME_W = 30;

  typedef enum logic [1:0] {
    OP_WAIT  = 2'd0,
    OP_TMO   = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [REG_AW-1:0] reg_addr;
    logic [REG_DW-1:0] reg_data;
    logic [TIME_W-1:0] count;
  } cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_EXEC,
    ST_WAIT,
    ST_DONE
  } state_e;
endpackage

// File: rtl/cmdseq_decode.sv
module cmdseq_decode
  import cmdseq_pkg::*;
(
  input  logic [CMD_W-1:0] word,
  output cmd_t             cmd
);
  localparam int ADDR_LO = REG_DW;
  localparam int ADDR_HI = REG_DW + REG_AW - 1;

  always_comb begin
    cmd.reg_addr = word[ADDR_HI:ADDR_LO];
    cmd.reg_data = word[REG_DW-1:0];
    cmd.count    = word[TIME_W-1:0];
    if (word[CMD_W-1])
      cmd.op = OP_WRITE;
    else if (word[CMD_W-2])
      cmd.op = OP_TMO;
    else
      cmd.op = OP_WAIT;
  end
endmodule

// File: rtl/cmdseq_wait_ctr.sv
module cmdseq_wait_ctr #(
  parameter int CNT_W = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  // last counted cycle of the stall
  assign expire = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/cmdseq_pc.sv
module cmdseq_pc #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  output logic [ADDR_W-1:0] pc,
  output logic              at_end
);
  always_ff @(posedge clk) begin
    if (rst)
      pc <= '0;
    else if (load)
      pc <= start_addr;
    else if (step)
      pc <= pc + 1'b1;
  end

  assign at_end = (pc == end_addr);
endmodule

// File: rtl/cmdseq_engine.sv
module cmdseq_engine
  import cmdseq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [CMD_W-1:0]  mem_rdata,
  output logic              reg_wr_en,
  output logic [REG_AW-1:0] reg_wr_addr,
  output logic [REG_DW-1:0] reg_wr_data,
  output logic              tmo_start,
  output logic [TIME_W-1:0] tmo_count,
  output logic              done
);
  state_e state_q;
  cmd_t   cmd;
  logic   at_end;
  logic   expire;
  logic   busy;
  logic   in_wait;
  logic   in_exec;
  logic   stall;
  logic   advance;
  logic   pc_load;
  logic   pc_step;
  logic   wait_load;

  cmdseq_decode u_dec (
    .word (mem_rdata),
    .cmd  (cmd)
  );

  assign busy    = (state_q != ST_IDLE);
  assign in_wait = (state_q == ST_WAIT);
  assign in_exec = (state_q == ST_EXEC);

  assign stall     = (cmd.op == OP_WAIT) && (cmd.count != '0);
  assign wait_load = enable && in_exec && stall;
  assign advance   = enable && ((in_exec && !stall) || (in_wait && expire));
  assign pc_load   = enable && (state_q == ST_IDLE);
  assign pc_step   = advance && !at_end;

  cmdseq_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk        (clk),
    .rst        (rst),
    .load       (pc_load),
    .step       (pc_step),
    .start_addr (start_addr),
    .end_addr   (end_addr),
    .pc         (mem_addr),
    .at_end     (at_end)
  );

  cmdseq_wait_ctr #(.CNT_W(TIME_W)) u_wait (
    .clk      (clk),
    .rst      (rst),
    .clear    (!enable),
    .load     (wait_load),
    .load_val (cmd.count),
    .expire   (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      reg_wr_en   <= 1'b0;
      reg_wr_addr <= '0;
      reg_wr_data <= '0;
      tmo_start   <= 1'b0;
      tmo_count   <= '0;
      done        <= 1'b0;
    end else begin
      reg_wr_en <= 1'b0;
      tmo_start <= 1'b0;
      if (!enable) begin
        state_q <= ST_IDLE;
        done    <= 1'b0;
      end else begin
        case (state_q)
          ST_IDLE: state_q <= ST_READ;
          ST_READ: state_q <= ST_EXEC;
          ST_EXEC: begin
            case (cmd.op)
              OP_WRITE: begin
                reg_wr_en   <= 1'b1;
                reg_wr_addr <= cmd.reg_addr;
                reg_wr_data <= cmd.reg_data;
              end
              OP_TMO: begin
                tmo_start <= 1'b1;
                tmo_count <= cmd.count;
              end
              default: ;
            endcase
            if (stall)
              state_q <= ST_WAIT;
          end
          ST_WAIT: ;
          ST_DONE: ;
          default: state_q <= ST_IDLE;
        endcase
        if (advance) begin
          if (at_end) begin
            state_q <= ST_DONE;
            done    <= 1'b1;
          end else begin
            state_q <= ST_READ;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cmdseq_engine_chk.sv
module cmdseq_engine_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic [ADDR_W-1:0] start_addr,
  input logic [ADDR_W-1:0] end_addr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              reg_wr_en,
  input logic              tmo_start,
  input logic              done,
  input logic              busy,
  input logic              in_wait
);
  p_wr_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> !reg_wr_en);

  p_one_action_r3: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_en && tmo_start));

  p_tmo_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    tmo_start |=> !tmo_start);

  p_wait_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    in_wait |-> (!reg_wr_en && !tmo_start));

  p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (done && enable) |=> done);

  p_done_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> (!reg_wr_en && !tmo_start));

  p_abort_r8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!done && !reg_wr_en && !tmo_start && !busy));

  p_addr_window_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> (mem_addr >= start_addr && mem_addr <= end_addr));

  p_addr_step_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && mem_addr != $past(mem_addr))
      |-> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));
endmodule

bind cmdseq_engine cmdseq_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .enable     (enable),
  .start_addr (start_addr),
  .end_addr   (end_addr),
  .mem_addr   (mem_addr),
  .reg_wr_en  (reg_wr_en),
  .tmo_start  (tmo_start),
  .done       (done),
  .busy       (busy),
  .in_wait    (in_wait)
);

// File: tb/cmdseq_engine_test.sv
module cmdseq_engine_test;
  localparam int AW    = 5;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] end_addr = '0;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_rdata = '0;
  logic          reg_wr_en;
  logic [6:0]    reg_wr_addr;
  logic [23:0]   reg_wr_data;
  logic          tmo_start;
  logic [29:0]   tmo_count;
  logic          done;

  logic [31:0] mem [DEPTH];

  cmdseq_engine #(.ADDR_W(AW)) uut (
    .clk, .rst, .enable, .start_addr, .end_addr, .mem_addr, .mem_rdata,
    .reg_wr_en, .reg_wr_addr, .reg_wr_data, .tmo_start, .tmo_count, .done
  );

  always #10 clk = ~clk;
  always @(posedge clk) mem_rdata <= mem[mem_addr];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0;
  int nfail = 0;
  int base = 0;
  int nw = 0;
  int nt = 0;
  int done_k = -1;
  int wr_k [16];
  logic [6:0]  wr_a [16];
  logic [23:0] wr_d [16];
  int tmo_k = -1;
  logic [29:0] tmo_v = '0;

  // event log, edges counted from the first edge that sees enable high
  always @(negedge clk) begin
    if (reg_wr_en && nw < 16) begin
      wr_k[nw] = cyc - base - 1;
      wr_a[nw] = reg_wr_addr;
      wr_d[nw] = reg_wr_data;
      nw++;
    end
    if (tmo_start) begin
      tmo_k = cyc - base - 1;
      tmo_v = tmo_count;
      nt++;
    end
    if (done && done_k < 0) done_k = cyc - base - 1;
  end

  function automatic logic [31:0] c_wr(input logic [6:0] a, input logic [23:0] d);
    return {1'b1, a, d};
  endfunction
  function automatic logic [31:0] c_wait(input logic [29:0] n);
    return {2'b00, n};
  endfunction
  function automatic logic [31:0] c_tmo(input logic [29:0] n);
    return {2'b01, n};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go(input int s, input int e);
    @(negedge clk);
    start_addr = AW'(s);
    end_addr   = AW'(e);
    nw = 0; nt = 0; done_k = -1; tmo_k = -1;
    base = cyc;
    enable = 1'b1;
  endtask

  task automatic wait_done(input int lim);
    for (int i = 0; i < lim && done_k < 0; i++) @(negedge clk);
  endtask

  task automatic stop;
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
  endtask

  // table: wait length, expected done edge, expected gap between the writes
  localparam int NV = 5;
  localparam int TV_WAIT [NV] = '{0, 1, 2, 5, 17};
  localparam int TV_DONE [NV] = '{6, 7, 8, 11, 23};
  localparam int TV_GAP  [NV] = '{4, 5, 6, 9, 21};

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !reg_wr_en && !tmo_start, "R1 outputs low in reset", done, 0);
    chk(mem_addr == '0, "R1 address zero in reset", mem_addr, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !reg_wr_en && !tmo_start, "R1 outputs low after reset", done, 0);

    // R2 R3 R4 R6 table of wait lengths
    for (int v = 0; v < NV; v++) begin
      mem[0] = c_wr(7'h11, 24'(v + 1));
      mem[1] = c_wait(30'(TV_WAIT[v]));
      mem[2] = c_wr(7'h22, 24'h5A0000 + 24'(v));
      go(0, 2);
      wait_done(100);
      chk(done_k == TV_DONE[v], "R6 done edge", done_k, TV_DONE[v]);
      chk(nw == 2, "R4 wait issues no write", nw, 2);
      chk(wr_k[0] == 2, "R2 first command on edge 2", wr_k[0], 2);
      chk(wr_k[1] - wr_k[0] == TV_GAP[v], "R4 wait adds N cycles", wr_k[1] - wr_k[0], TV_GAP[v]);
      chk(wr_a[0] == 7'h11 && wr_d[0] == 24'(v + 1), "R3 first write fields", wr_d[0], v + 1);
      chk(wr_a[1] == 7'h22 && wr_d[1] == 24'h5A0000 + 24'(v), "R3 second write fields", wr_d[1], 24'h5A0000 + v);
      chk(nt == 0, "R4 no timeout launch", nt, 0);
      stop();
      chk(!done, "R7 done cleared after enable low", done, 0);
    end

    // R5 timeout does not stall; R3 bit 30 belongs to the address
    mem[4] = c_wr(7'h40, 24'hABCDEF);
    mem[5] = c_tmo(30'h3FFFFFFF);
    mem[6] = c_wr(7'h7F, 24'hFFFFFF);
    go(4, 6);
    wait_done(100);
    chk(nt == 1 && tmo_k == 4, "R5 timeout pulse on edge 4", tmo_k, 4);
    chk(tmo_v == 30'h3FFFFFFF, "R5 timeout count", tmo_v, 30'h3FFFFFFF);
    chk(nw == 2 && wr_k[1] == 6, "R5 no stall after timeout", wr_k[1], 6);
    chk(wr_a[0] == 7'h40 && wr_d[0] == 24'hABCDEF, "R3 address bit 30 set", wr_a[0], 7'h40);
    chk(wr_a[1] == 7'h7F && wr_d[1] == 24'hFFFFFF, "R3 all-ones fields", wr_d[1], 24'hFFFFFF);
    chk(done_k == 6, "R6 done after timeout program", done_k, 6);
    // R6 done holds, nothing else runs
    repeat (10) @(negedge clk);
    chk(done && nw == 2 && nt == 1, "R6 done held and quiet", nw, 2);
    stop();
    chk(!done, "R7 done cleared", done, 0);

    // R6 trailing wait
    mem[8] = c_wr(7'h03, 24'h000777);
    mem[9] = c_wait(30'd3);
    go(8, 9);
    wait_done(100);
    chk(done_k == 7, "R6 done after trailing wait", done_k, 7);
    chk(nw == 1, "R6 single write", nw, 1);
    stop();

    // R8 abort during a long wait, then R7 rerun
    mem[12] = c_wr(7'h0A, 24'h000001);
    mem[13] = c_wait(30'd1000);
    mem[14] = c_wr(7'h0B, 24'h000002);
    go(12, 14);
    repeat (20) @(negedge clk);
    enable = 1'b0;
    repeat (1100) @(negedge clk);
    chk(nw == 1 && !done, "R8 abort drops the wait", nw, 1);
    go(12, 14);
    wait_done(2000);
    chk(done_k == 1006, "R7 rerun completes", done_k, 1006);
    chk(nw == 2 && wr_k[0] == 2 && wr_d[1] == 24'h000002, "R7 rerun from start address", wr_k[0], 2);
    stop();

    // R9 window at the top of memory
    mem[29] = c_wr(7'h1D, 24'h00001D);
    mem[30] = c_wr(7'h1E, 24'h00001E);
    mem[31] = c_wr(7'h1F, 24'h00001F);
    mem[0]  = c_wr(7'h00, 24'hBAD000);
    go(29, 31);
    wait_done(100);
    chk(nw == 3 && done_k == 6, "R9 top window count", nw, 3);
    chk(wr_d[0] == 24'h1D && wr_d[1] == 24'h1E && wr_d[2] == 24'h1F, "R9 ascending order", wr_d[2], 24'h1F);
    repeat (6) @(negedge clk);
    chk(nw == 3, "R9 no wrap past top", nw, 3);
    stop();

    // R9 single-command window
    mem[20] = c_wr(7'h14, 24'h001414);
    mem[21] = c_wr(7'h15, 24'h001515);
    go(20, 20);
    wait_done(100);
    chk(nw == 1 && wr_d[0] == 24'h001414, "R9 single command", nw, 1);
    chk(done_k == 2, "R6 done with single command", done_k, 2);
    stop();

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule